// File: doc/BRIEF.md
# Coherence Message Wire-Class Steering Unit

This unit sits at the network interface of a cache or directory controller. For each outgoing coherence message it chooses one of three wire classes. The baseline class (B) is for messages that need full width. The fast narrow class (L) is a 24-bit channel for short, latency-sensitive messages. The power-saving class (PW) is for traffic that is rarely on the critical path. The choice uses the message type, a hint from the directory, whether the payload operand is narrow, and a live count of directory congestion. When L is chosen, the unit also produces the compacted 24-bit word that travels on the narrow channel.

A message is offered through a valid/ready handshake. It is decided in the cycle it is accepted, and the result appears in a registered output stage on the next cycle. Directory busy and retry events are reported one per cycle on `busy_evt`. The unit counts them over a sliding window of the most recent `WINDOW` cycles. Negative acknowledgements use this count: they are sent on the fast wires while the directory is lightly loaded, and on the power-saving wires once the count rises above a threshold set by the `load_thresh` input.

Top module: `wire_steer`

## Requirements
- R1: `out_class` is coded as 0 = B, 1 = L, 2 = PW, and never takes the value 3. The following message types go to B (0):
  - full-address request, type 0;
  - response, type 1, when `excl_hint` is 0;
  - forwarded dirty copy, type 4;
  - reserved types 3 and 9 to 15.
- R2: These messages go to PW (2):
  - writeback data, type 2;
  - a response, type 1, sent while `excl_hint` is 1. This is the speculative reply of a read to an exclusively held block.
- R3: Unblock (type 5) and write-control (type 6) messages go to L (1).
- R4: A negative acknowledgement (type 7) goes to L when the directory load count is less than or equal to `load_thresh`. It goes to PW when the count is greater than `load_thresh`.
- R5: The directory load count is the number of cycles in which `busy_evt` was sampled high at one of the last `WINDOW` (256) rising clock edges before the decision. Events older than the window no longer count.
- R6: A narrow-operand message (type 8) goes to L when `operand` bits [31:8] are all zero or all one. Otherwise it goes to B.
- R7: When the class is L, `out_narrow` is laid out as follows:
  - [23:22] kind: unblock = 0, write-control = 1, negative acknowledgement = 2, narrow-operand = 3;
  - [21:18] `src`;
  - [17:14] `dst`;
  - [13:8] `mshr_id`;
  - [7:0] `operand[7:0]`.

  For any other class, `out_narrow` is zero.
- R8: `in_ready` is high when the output stage is empty or `out_ready` is high. A message accepted at a clock edge appears with `out_valid` after that same edge. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_class` and `out_narrow` hold their values.
- R9: While `rst_n` is low, the output stage is empty (`out_valid` = 0) and the load count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Message offered |
| in_ready | output | 1 | Unit can accept a message |
| msg_type | input | 4 | Message type code |
| excl_hint | input | 1 | Directory forwarded this read to an exclusive owner |
| src | input | 4 | Source node |
| dst | input | 4 | Destination node |
| mshr_id | input | 6 | Miss-status register identifier |
| operand | input | 32 | Payload operand |
| busy_evt | input | 1 | Directory busy/retry event this cycle |
| load_thresh | input | 9 | Load count above which the directory is treated as highly loaded |
| out_valid | output | 1 | Decision available |
| out_ready | input | 1 | Downstream takes the decision |
| out_class | output | 2 | Selected wire class |
| out_narrow | output | 24 | Compacted narrow-channel word |

## Verification
The properties assume that the message fields are stable while `in_valid` is high and that a message is counted only when the handshake completes. The driver changes the fields only just after a rising edge and only after the previous message has been accepted. The negative-acknowledgement checks assume the load count changes only through `busy_evt`. The stimulus therefore bursts busy events and then sends the message well inside the 256-cycle window. It also waits more than a full window before it relies on the count having drained. Downstream stalls follow a fixed repeating pattern, so the hold behaviour is exercised without making a decision wait long enough for events to leave the window.

// File: rtl/wire_steer.sv
module wire_steer #(
  parameter int TYPE_W      = 4,
  parameter int NODE_W      = 4,
  parameter int MSHR_W      = 6,
  parameter int OPND_W      = 32,
  parameter int NARROW_BITS = 8,
  parameter int LCH_W       = 24,
  parameter int WINDOW      = 256,
  localparam int CNT_W      = $clog2(WINDOW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TYPE_W-1:0] msg_type,
  input  logic              excl_hint,
  input  logic [NODE_W-1:0] src,
  input  logic [NODE_W-1:0] dst,
  input  logic [MSHR_W-1:0] mshr_id,
  input  logic [OPND_W-1:0] operand,
  input  logic              busy_evt,
  input  logic [CNT_W-1:0]  load_thresh,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_class,
  output logic [LCH_W-1:0]  out_narrow
);
  localparam logic [1:0] CL_B = 2'd0, CL_L = 2'd1, CL_PW = 2'd2;

  logic [WINDOW-1:0] hist;
  logic [CNT_W-1:0]  load_cnt;
  logic              load_high, opnd_narrow, take;
  logic [1:0]        cls, kind;
  logic [OPND_W-NARROW_BITS-1:0] upper;

  assign take      = in_valid && in_ready;
  assign in_ready  = !out_valid || out_ready;
  assign load_high = load_cnt > load_thresh;
  assign upper     = operand[OPND_W-1:NARROW_BITS];
  assign opnd_narrow = (upper == '0) || (upper == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist     <= '0;
      load_cnt <= '0;
    end else begin
      hist     <= {hist[WINDOW-2:0], busy_evt};
      load_cnt <= load_cnt + CNT_W'(busy_evt) - CNT_W'(hist[WINDOW-1]);
    end
  end

  always_comb begin
    cls  = CL_B;
    kind = 2'd0;
    case (msg_type)
      TYPE_W'(1): cls = excl_hint ? CL_PW : CL_B;
      TYPE_W'(2): cls = CL_PW;
      TYPE_W'(5): begin cls = CL_L; kind = 2'd0; end
      TYPE_W'(6): begin cls = CL_L; kind = 2'd1; end
      TYPE_W'(7): begin cls = load_high ? CL_PW : CL_L; kind = 2'd2; end
      TYPE_W'(8): begin cls = opnd_narrow ? CL_L : CL_B; kind = 2'd3; end
      default:    cls = CL_B;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_class  <= CL_B;
      out_narrow <= '0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_class  <= cls;
      out_narrow <= (cls == CL_L)
                    ? LCH_W'({kind, src, dst, mshr_id, operand[NARROW_BITS-1:0]})
                    : '0;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

module wire_steer_chk #(
  parameter int TYPE_W = 4,
  parameter int LCH_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [TYPE_W-1:0] msg_type,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_class,
  input logic [LCH_W-1:0]  out_narrow
);
  assert_reset_R9: assert property (@(posedge clk) !rst_n |=> !out_valid);

  assert_class_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_class != 2'd3);

  assert_wb_pw_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && msg_type == TYPE_W'(2) |=> out_class == 2'd2);

  assert_unblock_l_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (msg_type == TYPE_W'(5) || msg_type == TYPE_W'(6))
    |=> out_class == 2'd1);

  assert_nack_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && msg_type == TYPE_W'(7) |=> out_class != 2'd0);

  assert_narrow_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class != 2'd1 |-> out_narrow == '0);

  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_stall_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_class) && $stable(out_narrow));
endmodule

bind wire_steer wire_steer_chk #(.TYPE_W(TYPE_W), .LCH_W(LCH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .msg_type(msg_type), .out_valid(out_valid), .out_ready(out_ready),
  .out_class(out_class), .out_narrow(out_narrow)
);

// File: tb/wire_steer_bench.sv
module wire_steer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_ready;
  logic [3:0]  msg_type = 0;
  logic        excl_hint = 0;
  logic [3:0]  src = 0, dst = 0;
  logic [5:0]  mshr_id = 0;
  logic [31:0] operand = 0;
  logic        busy_evt = 0;
  logic [8:0]  load_thresh = 9'd4;
  logic        out_valid, out_ready = 1;
  logic [1:0]  out_class;
  logic [23:0] out_narrow;

  int tests = 0, fails = 0;
  bit bp_en = 0, done = 0;
  logic [25:0] exp_q[$];
  string       tag_q[$];

  wire_steer u_wire_steer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .msg_type(msg_type), .excl_hint(excl_hint), .src(src), .dst(dst),
    .mshr_id(mshr_id), .operand(operand), .busy_evt(busy_evt),
    .load_thresh(load_thresh), .out_valid(out_valid), .out_ready(out_ready),
    .out_class(out_class), .out_narrow(out_narrow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic send(string req, logic [3:0] t, logic h, logic [31:0] op,
                      logic [1:0] ecls, logic [1:0] kind);
    logic [23:0] en;
    @(posedge clk); #1;
    msg_type = t; excl_hint = h; operand = op;
    src = t; dst = ~t; mshr_id = {t, 2'b10};
    in_valid = 1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    en = (ecls == 2'd1) ? {kind, src, dst, mshr_id, op[7:0]} : 24'h0;
    exp_q.push_back({ecls, en});
    tag_q.push_back(req);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic busy_burst(int n);
    @(posedge clk); #1;
    busy_evt = 1;
    repeat (n) @(posedge clk);
    #1 busy_evt = 0;
  endtask

  task automatic drain();
    int k = 0;
    while ((exp_q.size() != 0 || out_valid) && k < 200) begin
      @(posedge clk); k++;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    #1 out_ready = bp_en ? (cyc % 3 != 0) : 1'b1;
  end

  logic        was_stalled = 0;
  logic [25:0] held;
  always @(negedge clk) begin
    if (rst_n) begin
      if (was_stalled)
        check("R8 hold", {6'd0, out_valid, out_class, out_narrow}, {6'd0, 1'b1, held});
      was_stalled = out_valid && !out_ready;
      held = {out_class, out_narrow};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check("R8 spurious", 1, 0);
        else begin
          logic [25:0] e;
          string s;
          e = exp_q.pop_front();
          s = tag_q.pop_front();
          check({s, " class"}, {30'd0, out_class}, {30'd0, e[25:24]});
          check({s, " narrow R7"}, {8'd0, out_narrow}, {8'd0, e[23:0]});
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset out_valid", {31'd0, out_valid}, 0);
    check("R8 reset in_ready", {31'd0, in_ready}, 1);
    rst_n = 1;

    send("R1 request", 4'd0, 0, 32'h1234, 2'd0, 0);
    send("R1 response", 4'd1, 0, 32'h0, 2'd0, 0);
    send("R1 fwd dirty", 4'd4, 1, 32'h0, 2'd0, 0);
    send("R1 reserved3", 4'd3, 0, 32'h5, 2'd0, 0);
    send("R1 reserved15", 4'd15, 0, 32'h5, 2'd0, 0);
    send("R2 writeback", 4'd2, 0, 32'hdead, 2'd2, 0);
    send("R2 spec reply", 4'd1, 1, 32'h0, 2'd2, 0);
    send("R3 unblock", 4'd5, 0, 32'h3c, 2'd1, 2'd0);
    send("R3 wrctrl", 4'd6, 1, 32'hffffffa5, 2'd1, 2'd1);
    send("R6 narrow pos", 4'd8, 0, 32'h0000007f, 2'd1, 2'd3);
    send("R6 narrow 0x80", 4'd8, 0, 32'h00000080, 2'd1, 2'd3);
    send("R6 narrow neg", 4'd8, 0, 32'hffffff80, 2'd1, 2'd3);
    send("R6 narrow neg2", 4'd8, 0, 32'hffffff00, 2'd1, 2'd3);
    send("R6 wide 0x100", 4'd8, 0, 32'h00000100, 2'd0, 0);
    send("R6 wide msb", 4'd8, 0, 32'h80000000, 2'd0, 0);
    drain();

    bp_en = 1;
    for (int i = 0; i < 12; i++)
      send("R8 backpressure", (i % 2) ? 4'd5 : 4'd2, 0, 32'(i), (i % 2) ? 2'd1 : 2'd2, 0);
    drain();
    bp_en = 0;

    load_thresh = 9'd0;
    send("R4 nack idle", 4'd7, 0, 32'h11, 2'd1, 2'd2);
    busy_burst(5);
    load_thresh = 9'd4;
    send("R4 nack high", 4'd7, 0, 32'h22, 2'd2, 0);
    load_thresh = 9'd5;
    send("R4 nack equal", 4'd7, 0, 32'h33, 2'd1, 2'd2);
    busy_burst(1);
    send("R5 nack six", 4'd7, 0, 32'h44, 2'd2, 0);
    drain();
    repeat (300) @(posedge clk);
    #1 load_thresh = 9'd0;
    send("R5 window expired", 4'd7, 0, 32'h55, 2'd1, 2'd2);
    drain();

    rst_n = 0;
    busy_burst(3);
    @(posedge clk); #1;
    rst_n = 1;
    send("R9 count cleared", 4'd7, 0, 32'h66, 2'd1, 2'd2);
    drain();

    check("R8 queue empty", exp_q.size(), 0);
    finish_run();
  end
endmodule